// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to an I2C bus without taking part in its traffic. It brings the SCL and SDA lines into the system clock domain, finds START and STOP conditions, and shifts in each 9-bit word: eight data bits followed by the acknowledge bit. The first word after a START is treated as an address. The upper seven bits of that word are compared against a set of programmable slave address slots. When the address qualifies, the block follows the transaction and reports each later byte.

A qualifying address, or any address when the accept-all mode is on, raises an address interrupt. Each byte received in a followed transaction raises a data interrupt. The last word is kept in a holding buffer, together with its observed acknowledge bit and an address/data marker. The buffer stays unchanged until the next qualifying word completes, which gives software at least one full word time to read it.

The block never drives SDA. A control bit selects how it treats SCL. With the bit clear, SCL is always released. With the bit set, the block holds SCL low after a qualifying word, as an ordinary slave would, until software services the interrupt.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, irq, irqAddr, irqData, overrun, sclOutEn and sdaOutEn are all 0, and bufData is 0x00.
- R2: sdaOutEn is 0 at all times, so the block never drives data or an acknowledge onto SDA.
- R3: With ctrlBits bit 0 (monitor enable) at 0, no interrupt flag is raised and sclOutEn stays 0, whatever the values of ctrlBits bits 1 and 2.
- R4: With ctrlBits = 3'b001, an address byte whose bits [7:1] equal an enabled slot raises irqAddr. bufData then holds the full byte, bufIsAddr is 1, rwFlag equals byte bit 0, and matchIdx is the lowest enabled matching slot. A slot whose slotEn bit is 0 never matches.
- R5: With ctrlBits bit 2 (accept-all) at 0, an address that matches no enabled slot raises no interrupt and leaves the buffer unchanged. The data bytes of that transaction are also ignored.
- R6: With ctrlBits = 3'b101, every address byte raises irqAddr and is loaded into bufData.
- R7: In a followed transaction, each data byte raises irqData and is loaded into bufData, with bufIsAddr = 0. The ninth bit is reported on bufAck, where 0 means ACK and 1 means NACK.
- R8: bufData holds its value while a later word is still being shifted in, and changes only when that word completes.
- R9: A one-cycle bufRd pulse clears irqData and overrun. If a word is loaded while the previous one is still unread, overrun is set and bufData takes the new word.
- R10: A one-cycle ackIrq pulse clears irqAddr. irq equals irqAddr OR irqData.
- R11: With ctrlBits bit 1 (SCL hold enable) at 0, sclOutEn is never asserted.
- R12: With ctrlBits = 3'b011, sclOutEn goes to 1 once SCL falls after a qualifying word. It stays at 1 until an ackIrq or bufRd pulse.
- R13: A repeated START restarts the bit count, and the next word is treated as an address. Words clocked after a STOP with no new START are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sensed level of the SCL line |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclOutEn | output | 1 | 1 pulls SCL low (clock hold) |
| sdaOutEn | output | 1 | 1 would pull SDA low; always 0 |
| ctrlBits | input | 3 | Bit 0 monitor enable, bit 1 SCL hold enable, bit 2 accept all addresses |
| slotAddr | input | NUM_SLOTS*7 | Seven-bit slave addresses, slot i at bits [7i+6:7i] |
| slotEn | input | NUM_SLOTS | Per-slot enable |
| ackIrq | input | 1 | Software service pulse: clears irqAddr and releases a clock hold |
| bufRd | input | 1 | Buffer read pulse: clears irqData and overrun, and releases a clock hold |
| irq | output | 1 | Combined interrupt |
| irqAddr | output | 1 | Address interrupt flag |
| irqData | output | 1 | Data interrupt flag |
| bufData | output | 8 | Last buffered byte |
| bufAck | output | 1 | Ninth bit observed with the buffered byte |
| bufIsAddr | output | 1 | Buffered byte was an address |
| rwFlag | output | 1 | Read/write bit of the last qualifying address |
| overrun | output | 1 | A word was loaded over an unread one |
| matchIdx | output | IDX_W | Lowest matching slot of the last qualifying address |

## Verification
The bench targets a repeated START that arrives in the middle of a word. A design that keeps counting would treat the next address as data and misalign every later byte. It also checks that a disabled slot holding the same address as an enabled one does not win the match index; a wrong priority encoder or an unmasked comparator would report the wrong slot. A second data byte is sent without a read in between. A design without overrun tracking would lose that event silently, and a buffer that updates during shifting would show a partial byte in mid-word. Clock hold is checked to stay active for many cycles until a service pulse, and to stay off when its enable bit or the monitor enable is clear.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int WORD_BITS = BYTE_W + 1;

  typedef struct packed {
    logic shiftEn;
    logic bitVal;
    logic loadWord;
    logic wordIsAddr;
    logic ackBit;
  } mon_strobe_t;
endpackage

// File: rtl/i2cmon_ctrl.sv
module i2cmon_ctrl
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  ctrlBits,
  input  logic        addrHit,
  input  logic        ackIrq,
  input  logic        bufRd,
  output mon_strobe_t strobes,
  output logic        sclOutEn,
  output logic        irqAddr,
  output logic        irqData,
  output logic        overrun
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, startCond, stopCond;
  logic monEn, holdEn, acceptAll;
  logic active, firstWord, selected, bufFull;
  logic stretchPend, stretching;
  logic [CNT_W-1:0] bitCnt;
  logic wordDone, qualify, service;

  assign monEn     = ctrlBits[0];
  assign holdEn    = ctrlBits[0] & ctrlBits[1];
  assign acceptAll = ctrlBits[0] & ctrlBits[2];

  // synchronizer chains, idle bus level is high
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  assign sclRise   = sclS & ~sclP;
  assign startCond = sclS & sclP & sdaP & ~sdaS;
  assign stopCond  = sclS & sclP & ~sdaP & sdaS;

  assign wordDone = monEn & active & sclRise & (bitCnt == LAST_BIT);
  assign qualify  = firstWord ? (acceptAll | addrHit) : selected;
  assign service  = ackIrq | bufRd;

  always_comb begin
    strobes.shiftEn    = monEn & active & sclRise & (bitCnt != LAST_BIT);
    strobes.bitVal     = sdaS;
    strobes.loadWord   = wordDone & qualify;
    strobes.wordIsAddr = firstWord;
    strobes.ackBit     = sdaS;
  end

  // frame tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      firstWord <= 1'b0;
      selected  <= 1'b0;
      bitCnt    <= '0;
    end else if (!monEn) begin
      active    <= 1'b0;
      firstWord <= 1'b0;
      selected  <= 1'b0;
      bitCnt    <= '0;
    end else if (startCond) begin
      active    <= 1'b1;
      firstWord <= 1'b1;
      selected  <= 1'b0;
      bitCnt    <= '0;
    end else if (stopCond) begin
      active    <= 1'b0;
      firstWord <= 1'b0;
      selected  <= 1'b0;
      bitCnt    <= '0;
    end else if (active && sclRise) begin
      if (bitCnt == LAST_BIT) begin
        bitCnt    <= '0;
        firstWord <= 1'b0;
        if (firstWord) selected <= qualify;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // interrupt and buffer flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqAddr <= 1'b0;
      irqData <= 1'b0;
      bufFull <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (strobes.loadWord && strobes.wordIsAddr) irqAddr <= 1'b1;
      else if (ackIrq)                            irqAddr <= 1'b0;

      if (strobes.loadWord && !strobes.wordIsAddr) irqData <= 1'b1;
      else if (bufRd)                              irqData <= 1'b0;

      if (strobes.loadWord) bufFull <= 1'b1;
      else if (bufRd)       bufFull <= 1'b0;

      if (strobes.loadWord && bufFull && !bufRd) overrun <= 1'b1;
      else if (bufRd)                            overrun <= 1'b0;
    end
  end

  // clock hold: armed by a qualifying word, applied once SCL is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stretchPend <= 1'b0;
      stretching  <= 1'b0;
    end else if (!holdEn || service || stopCond) begin
      stretchPend <= 1'b0;
      stretching  <= 1'b0;
    end else if (strobes.loadWord) begin
      stretchPend <= 1'b1;
    end else if (stretchPend && !sclS) begin
      stretchPend <= 1'b0;
      stretching  <= 1'b1;
    end
  end

  assign sclOutEn = stretching & holdEn;
endmodule

// File: rtl/i2cmon_dpath.sv
module i2cmon_dpath
  import i2cmon_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  mon_strobe_t                 strobes,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotAddr,
  input  logic [NUM_SLOTS-1:0]        slotEn,
  output logic                        addrHit,
  output logic [BYTE_W-1:0]           bufData,
  output logic                        bufAck,
  output logic                        bufIsAddr,
  output logic                        rwFlag,
  output logic [IDX_W-1:0]            matchIdx
);
  logic [BYTE_W-1:0]    shReg;
  logic [NUM_SLOTS-1:0] hitVec;
  logic [IDX_W-1:0]     firstIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (strobes.shiftEn) shReg <= {shReg[BYTE_W-2:0], strobes.bitVal};
  end

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
      assign hitVec[i] = slotEn[i] &&
                         (slotAddr[i*ADDR_W +: ADDR_W] == shReg[BYTE_W-1:1]);
    end
  endgenerate

  assign addrHit = |hitVec;

  always_comb begin
    firstIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hitVec[i]) firstIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufData   <= '0;
      bufAck    <= 1'b0;
      bufIsAddr <= 1'b0;
      rwFlag    <= 1'b0;
      matchIdx  <= '0;
    end else if (strobes.loadWord) begin
      bufData   <= shReg;
      bufAck    <= strobes.ackBit;
      bufIsAddr <= strobes.wordIsAddr;
      if (strobes.wordIsAddr) begin
        rwFlag   <= shReg[0];
        matchIdx <= firstIdx;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  output logic                        sclOutEn,
  output logic                        sdaOutEn,
  input  logic [2:0]                  ctrlBits,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotAddr,
  input  logic [NUM_SLOTS-1:0]        slotEn,
  input  logic                        ackIrq,
  input  logic                        bufRd,
  output logic                        irq,
  output logic                        irqAddr,
  output logic                        irqData,
  output logic [BYTE_W-1:0]           bufData,
  output logic                        bufAck,
  output logic                        bufIsAddr,
  output logic                        rwFlag,
  output logic                        overrun,
  output logic [IDX_W-1:0]            matchIdx
);
  mon_strobe_t strobes;
  logic addrHit;

  i2cmon_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctrlBits(ctrlBits), .addrHit(addrHit), .ackIrq(ackIrq), .bufRd(bufRd),
    .strobes(strobes), .sclOutEn(sclOutEn), .irqAddr(irqAddr),
    .irqData(irqData), .overrun(overrun)
  );

  i2cmon_dpath #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .slotAddr(slotAddr),
    .slotEn(slotEn), .addrHit(addrHit), .bufData(bufData), .bufAck(bufAck),
    .bufIsAddr(bufIsAddr), .rwFlag(rwFlag), .matchIdx(matchIdx)
  );

  assign sdaOutEn = 1'b0;
  assign irq = irqAddr | irqData;
endmodule

// File: rtl/i2c_bus_monitor_chk.sv
module i2c_bus_monitor_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclOutEn,
  input logic [2:0] ctrlBits,
  input logic       ackIrq,
  input logic       bufRd,
  input logic       irqAddr,
  input logic       irqData,
  input logic       overrun,
  input logic [7:0] bufData,
  input logic       loadWord
);
  // R11 and R3: no clock hold unless both enables are set
  a_r11_no_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrlBits[0] && ctrlBits[1]) |-> !sclOutEn);

  // R8: buffer only changes on a completed qualifying word
  a_r8_buf_stable: assert property (@(posedge clk) disable iff (!rstN)
    !loadWord |=> $stable(bufData));

  // R9: read pulse clears data flag and overrun
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (bufRd && !loadWord) |=> (!irqData && !overrun));

  // R10: service pulse clears address flag
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ackIrq && !loadWord) |=> !irqAddr);

  // R12: hold persists until serviced or disabled
  a_r12_hold_until_serviced: assert property (@(posedge clk) disable iff (!rstN)
    (sclOutEn && !ackIrq && !bufRd) |=> (sclOutEn || !(ctrlBits[0] && ctrlBits[1])));
endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk chk_i (
  .clk(clk), .rstN(rstN), .sclOutEn(sclOutEn), .ctrlBits(ctrlBits),
  .ackIrq(ackIrq), .bufRd(bufRd), .irqAddr(irqAddr), .irqData(irqData),
  .overrun(overrun), .bufData(bufData), .loadWord(strobes.loadWord)
);

// File: tb/i2c_bus_monitor_tb_top.sv
`timescale 1ns/1ps
module i2c_bus_monitor_tb_top;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sclIn, sdaIn, sclOutEn, sdaOutEn;
  logic [2:0]  ctrlBits = 3'b000;
  logic [27:0] slotAddr = '0;
  logic [3:0]  slotEn = '0;
  logic ackIrq = 1'b0, bufRd = 1'b0;
  logic irq, irqAddr, irqData, bufAck, bufIsAddr, rwFlag, overrun;
  logic [7:0] bufData;
  logic [1:0] matchIdx;

  int checks = 0;
  int failures = 0;
  logic sawSdaDrive = 1'b0;
  logic sawHold = 1'b0;

  always #10 clk = ~clk;

  assign sclIn = sclDrv & ~sclOutEn;
  assign sdaIn = sdaDrv & ~sdaOutEn;

  i2c_bus_monitor dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclOutEn(sclOutEn), .sdaOutEn(sdaOutEn), .ctrlBits(ctrlBits),
    .slotAddr(slotAddr), .slotEn(slotEn), .ackIrq(ackIrq), .bufRd(bufRd),
    .irq(irq), .irqAddr(irqAddr), .irqData(irqData), .bufData(bufData),
    .bufAck(bufAck), .bufIsAddr(bufIsAddr), .rwFlag(rwFlag),
    .overrun(overrun), .matchIdx(matchIdx)
  );

  always @(negedge clk) begin
    if (rstN && sdaOutEn) sawSdaDrive <= 1'b1;
    if (rstN && sclOutEn) sawHold <= 1'b1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseAck();
    @(negedge clk); ackIrq = 1'b1;
    @(negedge clk); ackIrq = 1'b0;
    waitClk(2);
  endtask

  task automatic pulseRd();
    @(negedge clk); bufRd = 1'b1;
    @(negedge clk); bufRd = 1'b0;
    waitClk(2);
  endtask

  task automatic sendBit(input logic b);
    int guard = 0;
    sdaDrv = b;
    waitClk(H);
    sclDrv = 1'b1;
    while (!sclIn && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    waitClk(H);
    sclDrv = 1'b0;
    waitClk(H);
  endtask

  task automatic sendWord(input logic [7:0] b, input logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sendBit(ack);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitClk(H);
    sclDrv = 1'b1; waitClk(H);
    sdaDrv = 1'b0; waitClk(H);
    sclDrv = 1'b0; waitClk(H);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitClk(H);
    sclDrv = 1'b1; waitClk(H);
    sdaDrv = 1'b1; waitClk(H);
  endtask

  task automatic t_reset();
    check(irq == 0 && irqAddr == 0 && irqData == 0 && overrun == 0, "R1 flags", irq, 0);
    check(sclOutEn == 0 && sdaOutEn == 0, "R1 drives", {sclOutEn, sdaOutEn}, 0);
    check(bufData == 8'h00, "R1 bufData", bufData, 0);
  endtask

  task automatic t_disabled();
    ctrlBits = 3'b110;
    slotAddr[6:0] = 7'h50; slotEn = 4'b0001;
    busStart(); sendWord(8'hA0, 1'b0); sendWord(8'h55, 1'b0); busStop();
    check(irq == 0, "R3 no irq when off", irq, 0);
    check(sawHold == 0, "R3 no hold when off", sawHold, 0);
    check(bufData == 8'h00, "R3 buffer untouched", bufData, 0);
  endtask

  task automatic t_match();
    ctrlBits = 3'b001;
    slotAddr = '0;
    slotAddr[6:0]   = 7'h50;
    slotAddr[13:7]  = 7'h23;
    slotAddr[20:14] = 7'h23;
    slotEn = 4'b0101;
    busStart(); sendWord(8'h47, 1'b0);
    check(irqAddr == 1 && irq == 1, "R4 addr irq", irqAddr, 1);
    check(matchIdx == 2'd2, "R4 matchIdx", matchIdx, 2);
    check(bufData == 8'h47 && bufIsAddr == 1, "R4 buffer addr", bufData, 8'h47);
    check(rwFlag == 1, "R4 rwFlag", rwFlag, 1);
    pulseAck();
    check(irqAddr == 0 && irq == 0, "R10 ack clears", irqAddr, 0);
    pulseRd();
    sendWord(8'h3C, 1'b1);
    check(irqData == 1 && bufData == 8'h3C, "R7 data load", bufData, 8'h3C);
    check(bufAck == 1 && bufIsAddr == 0, "R7 ack bit and marker", {bufAck, bufIsAddr}, 2);
    // first five bits of 0x81
    sendBit(1); sendBit(0); sendBit(0); sendBit(0); sendBit(0);
    check(bufData == 8'h3C, "R8 stable mid-word", bufData, 8'h3C);
    sendBit(0); sendBit(0); sendBit(1); sendBit(0);
    check(bufData == 8'h81 && overrun == 1, "R9 overrun", {overrun, bufData}, 9'h181);
    pulseRd();
    check(irqData == 0 && overrun == 0, "R9 read clears", {irqData, overrun}, 0);
    busStop();
  endtask

  task automatic t_nomatch();
    ctrlBits = 3'b001;
    busStart(); sendWord(8'hFC, 1'b1); sendWord(8'h11, 1'b0); busStop();
    check(irq == 0, "R5 no irq", irq, 0);
    check(bufData == 8'h81, "R5 buffer unchanged", bufData, 8'h81);
  endtask

  task automatic t_matchall();
    ctrlBits = 3'b101;
    busStart(); sendWord(8'hFC, 1'b1);
    check(irqAddr == 1 && bufData == 8'hFC, "R6 accept all", bufData, 8'hFC);
    pulseAck(); pulseRd(); busStop();
    check(sawHold == 0, "R11 no hold with bit1 clear", sawHold, 0);
  endtask

  task automatic t_stretch();
    ctrlBits = 3'b011;
    busStart(); sendWord(8'hA0, 1'b0);
    check(sclOutEn == 1 && sclIn == 0, "R12 hold applied", sclOutEn, 1);
    waitClk(40);
    check(sclOutEn == 1, "R12 hold persists", sclOutEn, 1);
    pulseAck();
    check(sclOutEn == 0, "R12 hold released", sclOutEn, 0);
    pulseRd();
    busStop();
  endtask

  task automatic t_restart();
    ctrlBits = 3'b001;
    busStart();
    sendBit(1); sendBit(0); sendBit(1); sendBit(1);
    busStart();
    sendWord(8'hA0, 1'b0);
    check(irqAddr == 1 && bufData == 8'hA0 && bufIsAddr == 1, "R13 repeated start", bufData, 8'hA0);
    pulseAck(); pulseRd();
    busStop();
    sendWord(8'hA0, 1'b0);
    check(irq == 0, "R13 ignored after stop", irq, 0);
    busStop();
    check(sawSdaDrive == 0, "R2 SDA never driven", sawSdaDrive, 0);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    t_reset();
    t_disabled();
    t_match();
    t_nomatch();
    t_matchall();
    t_stretch();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule